// File: doc/BRIEF.md
# Bus Launch-Capture Delay Tester

This block runs one multi-cycle test operation on an external parallel bus. On a start strobe it latches a 16-bit test word. It drives that word onto the bus for a single clock with the output enable raised. It reads the same lines back on the very next clock edge. Because launch and capture sit one processor clock apart, a line that settles late loses the race and the captured value differs from the driven one. Slow rise or fall caused by coupling between neighbouring lines shows up this way.

The operation is fused into one sequence so that no instruction fetch or decode gap separates the write from the read. A pair of separate output and input operations would be several cycles apart. Any delay shorter than that gap would stay hidden. The surrounding processor only pulses start, waits for the done pulse and reads the captured word and the mismatch flag.

The controller walks through five named states:
- ST_IDLE: waits for start.
- ST_DRIVE: the output enable is high for this cycle only.
- ST_CAPTURE: the captured word is valid and the bus is released.
- ST_COMPARE: the difference is evaluated.
- ST_DONE: a one-cycle done pulse is given.

The transitions are:
- IDLE→DRIVE on an accepted start.
- DRIVE→CAPTURE, CAPTURE→COMPARE, COMPARE→DONE and DONE→IDLE, each unconditional.
- IDLE→IDLE without start.

Top module: `bus_delay_probe`

## Requirements
- R1: After reset `bus_oe`, `done` and `mismatch` are 0 and `cap_word` is 0.
- R2: A `start` seen high at a clock edge while idle latches `test_word`. For exactly one cycle after that edge, `bus_oe` is 1 and `bus_out` equals the latched word.
- R3: At the clock edge that ends the drive cycle (one clock after launch), `bus_in` is registered into `cap_word`.
- R4: `bus_oe` is 0 in the cycle after the capture edge and stays 0 until the next accepted start.
- R5: `mismatch` is 1 exactly when any bit of the captured word differs from the driven word. It is valid in the same cycle as `done`.
- R6: `mismatch` is cleared at the edge that accepts a start and otherwise holds its value (sticky) until then.
- R7: `done` is a single-cycle pulse in the fourth cycle after the start edge, i.e. three clocks after the drive cycle begins.
- R8: A `start` seen while an operation is in progress (drive, capture, compare or done cycle) is ignored. It changes neither the sequence nor the latched word, and it does not launch a new drive.
- R9: `cap_word` keeps its value from one capture edge until the next capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, also the bus test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins one launch-capture operation when idle |
| test_word | input | 16 | Word to launch, latched when start is accepted |
| bus_out | output | 16 | Value driven toward the bus under test |
| bus_oe | output | 1 | Output enable for the bus drivers |
| bus_in | input | 16 | Value read back from the bus lines |
| cap_word | output | 16 | Word captured one clock after launch |
| mismatch | output | 1 | Sticky flag: captured word differs from launched word |
| done | output | 1 | One-cycle pulse when results are valid |

## Verification
The bench models the bus two ways. In the first, a line fault inverts chosen bits while the driver is on. In the second, a slow bus shows its previous-cycle value at the capture edge, so a design that captured a cycle late, or held the enable too long, would report no mismatch where one is expected.

The bench pulses start during the drive cycle and again during the done cycle. A design that re-armed on either would raise the enable again or replace the latched word.

It also checks the following:
- The flag stays set across idle cycles and clears at the next accepted start. A non-sticky flag, or one cleared only at done, is caught.
- Done is measured to the exact cycle and must fall the cycle after it rises.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DRIVE   = 3'd1,
        ST_CAPTURE = 3'd2,
        ST_COMPARE = 3'd3,
        ST_DONE    = 3'd4
    } bdp_state_t;
endpackage

// File: rtl/bdp_fsm.sv
module bdp_fsm
    import bdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic drive_en,
    output logic cap_en,
    output logic cmp_en,
    output logic done
);
    bdp_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        drive_en = 1'b0;
        cap_en   = 1'b0;
        cmp_en   = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    state_d = ST_DRIVE;
                end
            end
            ST_DRIVE: begin
                drive_en = 1'b1;
                cap_en   = 1'b1;
                state_d  = ST_CAPTURE;
            end
            ST_CAPTURE: state_d = ST_COMPARE;
            ST_COMPARE: begin
                cmp_en  = 1'b1;
                state_d = ST_DONE;
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R2: drive window lasts one cycle
    a_r2_drive_single: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |=> !drive_en);
    // R7: done is one cycle wide
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: compare is followed by done
    a_r7_done_after_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> done);
    // R8: start while busy never opens a drive window
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q != ST_IDLE) |=> !drive_en);
endmodule

// File: rtl/bdp_diff.sv
module bdp_diff #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         any_diff
);
    logic [W-1:0] bit_diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_diff[i] = a[i] ^ b[i];
    end

    assign any_diff = |bit_diff;
endmodule

// File: rtl/bdp_datapath.sv
module bdp_datapath #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  logic         cap_en,
    input  logic         cmp_en,
    input  logic [W-1:0] test_word,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] launch_q,
    output logic [W-1:0] cap_q,
    output logic         flag_q
);
    logic diff;

    bdp_diff #(.W(W)) u_diff (
        .a        (launch_q),
        .b        (cap_q),
        .any_diff (diff)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launch_q <= '0;
            cap_q    <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (accept) launch_q <= test_word;
            if (cap_en) cap_q <= bus_in;
            if (accept)      flag_q <= 1'b0;
            else if (cmp_en) flag_q <= diff;
        end
    end

    // R3: capture register takes the bus value at the end of the drive cycle
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> cap_q == $past(bus_in));
    // R9: captured word holds between captures
    a_r9_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(cap_q));
    // R5: equal words give a clear flag, unequal words set it
    a_r5_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && launch_q == cap_q) |=> !flag_q);
    a_r5_unequal: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && launch_q != cap_q) |=> flag_q);
    // R6: flag is sticky and cleared by an accepted start
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !accept) |=> $stable(flag_q));
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !flag_q);
endmodule

// File: rtl/bus_delay_probe.sv
module bus_delay_probe #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] test_word,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] cap_word,
    output logic         mismatch,
    output logic         done
);
    logic accept, drive_en, cap_en, cmp_en;

    bdp_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .accept   (accept),
        .drive_en (drive_en),
        .cap_en   (cap_en),
        .cmp_en   (cmp_en),
        .done     (done)
    );

    bdp_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cap_en    (cap_en),
        .cmp_en    (cmp_en),
        .test_word (test_word),
        .bus_in    (bus_in),
        .launch_q  (bus_out),
        .cap_q     (cap_word),
        .flag_q    (mismatch)
    );

    assign bus_oe = drive_en;

    // R4: after the capture edge the enable is low
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |=> !bus_oe);
    // R2: launched word is the one latched at acceptance
    a_r2_launch_word: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (bus_oe && bus_out == $past(test_word)));
endmodule

// File: tb/sim_bus_delay_probe.sv
module sim_bus_delay_probe;
    localparam int W = 16;

    typedef struct packed {
        logic [W-1:0] cap;
        logic         mis;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] test_word = '0;
    logic [W-1:0] bus_out;
    logic         bus_oe;
    logic [W-1:0] bus_in;
    logic [W-1:0] cap_word;
    logic         mismatch;
    logic         done;

    logic         slow = 1'b0;
    logic [W-1:0] fault_mask = '0;
    logic [W-1:0] idle_val = '0;
    logic [W-1:0] lag_q = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    bus_delay_probe #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .test_word(test_word),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .cap_word(cap_word), .mismatch(mismatch), .done(done)
    );

    // bus model: fast lines with fault mask, or slow lines one cycle late
    always @(posedge clk) lag_q <= bus_oe ? bus_out : idle_val;
    assign bus_in = slow ? lag_q : (bus_oe ? (bus_out ^ fault_mask) : idle_val);

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // monitor: pops the scoreboard whenever done is seen
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected done", 16'(done), 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cap_word == e.cap, "R3 captured word", cap_word, e.cap);
                chk(mismatch == e.mis, "R5 mismatch flag", 16'(mismatch), 16'(e.mis));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            chk(1'b0, "watchdog", 16'(cycles), 16'd0);
            finish_run();
        end
    end

    // driver: one full operation with cycle-exact checks; pokes starts while busy if asked
    task automatic run_op(input logic [W-1:0] word, input logic [W-1:0] mask,
                          input bit slw, input logic [W-1:0] idl, input bit poke);
        exp_t e;
        fault_mask = mask;
        slow       = slw;
        idle_val   = idl;
        e.cap = slw ? idl : (word ^ mask);
        e.mis = (e.cap != word);
        sb.push_back(e);
        test_word = word;
        start     = 1'b1;
        @(negedge clk);                 // drive cycle
        chk(bus_oe == 1'b1, "R2 oe in drive cycle", 16'(bus_oe), 16'd1);
        chk(bus_out == word, "R2 launched word", bus_out, word);
        chk(mismatch == 1'b0, "R6 clear at start", 16'(mismatch), 16'd0);
        chk(done == 1'b0, "R7 no early done", 16'(done), 16'd0);
        start = poke;
        test_word = ~word;
        @(negedge clk);                 // capture cycle
        start = 1'b0;
        chk(bus_oe == 1'b0, "R4 oe released", 16'(bus_oe), 16'd0);
        chk(cap_word == e.cap, "R3 capture one clock after launch", cap_word, e.cap);
        chk(bus_out == word, "R8 latched word unchanged", bus_out, word);
        @(negedge clk);                 // compare cycle
        chk(done == 1'b0, "R7 no done in compare", 16'(done), 16'd0);
        chk(bus_oe == 1'b0, "R4 oe still low", 16'(bus_oe), 16'd0);
        @(negedge clk);                 // done cycle (monitor pops here)
        chk(done == 1'b1, "R7 done timing", 16'(done), 16'd1);
        start = poke;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R7 done single cycle", 16'(done), 16'd0);
        @(negedge clk);
        chk(bus_oe == 1'b0, "R8 no relaunch from start in done", 16'(bus_oe), 16'd0);
        chk(mismatch == e.mis, "R6 flag sticky", 16'(mismatch), 16'(e.mis));
        chk(cap_word == e.cap, "R9 captured word held", cap_word, e.cap);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(bus_oe == 1'b0, "R1 reset oe", 16'(bus_oe), 16'd0);
        chk(done == 1'b0, "R1 reset done", 16'(done), 16'd0);
        chk(mismatch == 1'b0, "R1 reset mismatch", 16'(mismatch), 16'd0);
        chk(cap_word == '0, "R1 reset captured word", cap_word, '0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(16'hA5C3, 16'h0000, 1'b0, 16'h0000, 1'b0);  // clean bus
        run_op(16'h1234, 16'h0100, 1'b0, 16'h0000, 1'b0);  // one stuck line
        run_op(16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b0);  // R6 clears previous flag
        run_op(16'h5A5A, 16'h0000, 1'b1, 16'h0000, 1'b0);  // slow bus, R5 delay seen
        run_op(16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0);  // slow bus, same value
        run_op(16'h8001, 16'h8001, 1'b0, 16'hFFFF, 1'b1);  // R8 pokes while busy

        // R6: flag holds across idle cycles
        repeat (5) @(negedge clk);
        chk(mismatch == 1'b1, "R6 flag holds while idle", 16'(mismatch), 16'd1);
        chk(bus_oe == 1'b0, "R4 idle oe low", 16'(bus_oe), 16'd0);
        chk(sb.size() == 0, "R7 every operation produced done", 16'(sb.size()), 16'd0);
        finish_run();
    end
endmodule